// File: doc/BRIEF.md
# In-Flight Instruction Window Tracker

This block follows every instruction that an out-of-order core has in flight, using a ring of 64 entries indexed by a 6-bit serial number. Each cycle it can hand out up to four new serial numbers, in program order. It records completion reports from the execution side; a report either marks an entry as done or marks it as failed. It then moves a commit pointer and a retire pointer forward in program order, and the two pointers have different per-cycle widths.

Commit moves over the longest run of finished, error-free entries that follows the last committed one, up to eight per cycle. Retire then frees committed entries for reuse, up to four per cycle. The outside resource logic can throttle retire with a permission count.

A backup request names a serial number S. The request discards every younger entry and winds the issue pointer back to S, which gives the core a way out of a misprediction or a failed instruction. All three pointers hold the most recently handled serial number, so the entry that is handed out next sits one slot past the issue pointer. The ring holds at most 63 active entries, because one slot always stays empty to keep a full ring distinct from an empty one.

Top module: `inflight_window`

## Requirements
- R1: After reset, the issue, commit and retire pointers all read 0, every entry is free, `full` is 0 and all per-cycle counts are 0.
- R2: `iss_grant` equals the smaller of `iss_req` (capped at 4) and the number of free slots, which is 63 minus (issue pointer minus retire pointer, modulo 64). The granted serial numbers start at `iss_first_sn`, which is the issue pointer plus 1. On the next edge the issue pointer advances by the grant.
- R3: `full` is 1 exactly when 63 entries are active. While it is 1, no serial number is granted, and a request that needs more slots than remain is granted only the remaining slots.
- R4: A completion report with `cpl_err` = 1 for a pending entry marks that entry as failed. Commit stops in front of a failed entry until a backup discards it.
- R5: `cmt_cnt` is the number of consecutive error-free completed entries that directly follow the commit pointer, capped at 8. On the next edge the commit pointer advances by that count.
- R6: `ret_cnt` is the number of consecutive committed entries that directly follow the retire pointer, capped at the smaller of 4 and `ret_allow`. On the next edge the retire pointer advances by that count and those entries become free.
- R7: A backup to S (with S no older than the commit pointer) frees every entry younger than S and sets the issue pointer to S on the next edge. In that cycle it grants no issue, and commit does not pass S.
- R8: A completion report for an entry that is not pending has no effect. For example, an error report that arrives after an error-free one does not block commit.
- R9: Serial numbers wrap modulo 64. Retired entries are handed out again after the pointers cross from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_req | input | 3 | Number of serial numbers requested this cycle (0..4) |
| iss_grant | output | 3 | Number of serial numbers granted this cycle |
| iss_first_sn | output | 6 | First serial number of this cycle's grant |
| cpl_vld | input | 2 | Completion report valid, one bit per report port |
| cpl_sn | input | 12 | Serial number of each report, port p at bits [6p+5:6p] |
| cpl_err | input | 2 | Report carries an error, one bit per port |
| bk_vld | input | 1 | Backup request |
| bk_sn | input | 6 | Serial number to back up to |
| ret_allow | input | 3 | Maximum retirements the resource side permits this cycle |
| isn_o | output | 6 | Most recently issued serial number |
| csn_o | output | 6 | Most recently committed serial number |
| rrp_o | output | 6 | Most recently retired serial number |
| full | output | 1 | Window holds 63 active entries |
| cmt_cnt | output | 4 | Entries committing this cycle |
| ret_cnt | output | 3 | Entries retiring this cycle |

## Verification
The bench first fills the ring to 63 active entries. It expects a grant of 3 on the last partial request and a grant of 0 after that. A design that allowed a 64th entry would make a full ring look empty and lose every in-flight instruction.

It sends a late error report to an entry that has already finished. A design that accepted that report would stall commit forever. It also places a failed entry ahead of finished ones, which catches a design that commits past the fault.

Backups land on the commit pointer and at random points inside the window, including cycles that also carry completions and a competing issue request. A wrong design would either resurrect discarded entries or commit an instruction beyond S. A long sweep carries the pointers past 63 many times under throttled retirement, which exposes any modulo error in the scans near the wrap.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int SN_W  = 6;
    localparam int DEPTH = 1 << SN_W;

    typedef logic [SN_W-1:0] sn_t;

    // Per-entry lifecycle. Waiting and executing are both folded into PEND.
    typedef enum logic [2:0] {
        ST_FREE = 3'd0,
        ST_PEND = 3'd1,
        ST_DONE = 3'd2,
        ST_FAIL = 3'd3,
        ST_CMTD = 3'd4
    } ent_state_e;

    // Forward distance on the ring from one serial number to another.
    function automatic sn_t sn_dist(input sn_t from_sn, input sn_t to_sn);
        return to_sn - from_sn;
    endfunction

    function automatic sn_t sn_step(input sn_t base, input int unsigned k);
        return base + sn_t'(k);
    endfunction

endpackage

// File: rtl/wt_inorder_scan.sv
// Counts the leading run of set bits in 'match', capped at 'limit'.
module wt_inorder_scan #(
    parameter int W  = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  match,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count
);
    logic stop;

    always_comb begin
        count = '0;
        stop  = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!stop && match[i] && (CW'(i) < limit)) begin
                count = CW'(i + 1);
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wt_issue_ctl.sv
module wt_issue_ctl
    import wt_pkg::*;
#(
    parameter int ISSUE_W = 4,
    localparam int IW = $clog2(ISSUE_W + 1)
) (
    input  sn_t           isn,
    input  sn_t           rrp,
    input  logic [IW-1:0] req,
    input  logic          bk_vld,
    output logic [IW-1:0] grant,
    output logic          full
);
    sn_t           free_slots;
    logic [IW-1:0] req_cap;

    // One slot always stays empty so a full ring differs from an empty one.
    assign free_slots = sn_t'(DEPTH - 1) - sn_dist(rrp, isn);
    assign full       = (free_slots == '0);
    assign req_cap    = (int'(req) > ISSUE_W) ? IW'(ISSUE_W) : req;

    always_comb begin
        if (bk_vld) begin
            grant = '0;
        end else if (int'(free_slots) < int'(req_cap)) begin
            grant = IW'(free_slots);
        end else begin
            grant = req_cap;
        end
    end
endmodule

// File: rtl/wt_status_ring.sv
module wt_status_ring
    import wt_pkg::*;
#(
    parameter int ISSUE_W  = 4,
    parameter int COMMIT_W = 8,
    parameter int RETIRE_W = 4,
    parameter int CPL_N    = 2,
    localparam int IW = $clog2(ISSUE_W + 1),
    localparam int CW = $clog2(COMMIT_W + 1),
    localparam int RW = $clog2(RETIRE_W + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  sn_t                          isn,
    input  sn_t                          csn,
    input  sn_t                          rrp,
    input  logic [IW-1:0]                grant,
    input  logic [CW-1:0]                cmt_cnt,
    input  logic [RW-1:0]                ret_cnt,
    input  logic                         bk_vld,
    input  sn_t                          bk_sn,
    input  logic [CPL_N-1:0]             cpl_vld,
    input  sn_t [CPL_N-1:0]              cpl_sn,
    input  logic [CPL_N-1:0]             cpl_err,
    output ent_state_e [DEPTH-1:0]       state_q
);
    ent_state_e [DEPTH-1:0] state_d;
    logic [DEPTH-1:0]       cpl_hit [CPL_N];

    for (genvar p = 0; p < CPL_N; p++) begin : g_cpl_dec
        assign cpl_hit[p] = cpl_vld[p] ? (DEPTH'(1) << cpl_sn[p]) : '0;
    end

    always_comb begin
        state_d = state_q;
        for (int j = 0; j < DEPTH; j++) begin
            sn_t jsn;
            int  d_cmt, d_ret, d_bk, d_iss;
            jsn   = sn_t'(j);
            d_cmt = int'(sn_dist(csn, jsn));
            d_ret = int'(sn_dist(rrp, jsn));
            d_bk  = int'(sn_dist(bk_sn, jsn));
            d_iss = int'(sn_dist(isn, jsn));
            // Completion only lands on a pending entry.
            for (int p = 0; p < CPL_N; p++) begin
                if (cpl_hit[p][j] && state_q[j] == ST_PEND) begin
                    state_d[j] = cpl_err[p] ? ST_FAIL : ST_DONE;
                end
            end
            if (d_cmt != 0 && d_cmt <= int'(cmt_cnt)) begin
                state_d[j] = ST_CMTD;
            end
            if (d_ret != 0 && d_ret <= int'(ret_cnt)) begin
                state_d[j] = ST_FREE;
            end
            if (bk_vld && d_bk != 0 && d_bk <= int'(sn_dist(bk_sn, isn))) begin
                state_d[j] = ST_FREE;
            end
            if (d_iss != 0 && d_iss <= int'(grant)) begin
                state_d[j] = ST_PEND;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= {DEPTH{ST_FREE}};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/inflight_window.sv
module inflight_window
    import wt_pkg::*;
#(
    parameter int ISSUE_W  = 4,
    parameter int COMMIT_W = 8,
    parameter int RETIRE_W = 4,
    parameter int CPL_N    = 2,
    localparam int IW = $clog2(ISSUE_W + 1),
    localparam int CW = $clog2(COMMIT_W + 1),
    localparam int RW = $clog2(RETIRE_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IW-1:0]           iss_req,
    output logic [IW-1:0]           iss_grant,
    output logic [SN_W-1:0]         iss_first_sn,
    input  logic [CPL_N-1:0]        cpl_vld,
    input  logic [CPL_N*SN_W-1:0]   cpl_sn,
    input  logic [CPL_N-1:0]        cpl_err,
    input  logic                    bk_vld,
    input  logic [SN_W-1:0]         bk_sn,
    input  logic [RW-1:0]           ret_allow,
    output logic [SN_W-1:0]         isn_o,
    output logic [SN_W-1:0]         csn_o,
    output logic [SN_W-1:0]         rrp_o,
    output logic                    full,
    output logic [CW-1:0]           cmt_cnt,
    output logic [RW-1:0]           ret_cnt
);
    sn_t                    isn_q, csn_q, rrp_q;
    sn_t [CPL_N-1:0]        cpl_sn_a;
    ent_state_e [DEPTH-1:0] state_q;
    logic [COMMIT_W-1:0]    cmt_match;
    logic [RETIRE_W-1:0]    ret_match;
    logic [CW-1:0]          cmt_limit;
    logic [RW-1:0]          ret_limit;
    sn_t                    bk_span;

    assign cpl_sn_a = cpl_sn;

    wt_issue_ctl #(.ISSUE_W(ISSUE_W)) i_issue (
        .isn    (isn_q),
        .rrp    (rrp_q),
        .req    (iss_req),
        .bk_vld (bk_vld),
        .grant  (iss_grant),
        .full   (full)
    );

    // Commit window: entries after the commit pointer that finished cleanly.
    for (genvar i = 0; i < COMMIT_W; i++) begin : g_cmt_win
        assign cmt_match[i] = (state_q[sn_step(csn_q, i + 1)] == ST_DONE);
    end

    // Retire window: entries after the retire pointer already committed.
    for (genvar i = 0; i < RETIRE_W; i++) begin : g_ret_win
        assign ret_match[i] = (state_q[sn_step(rrp_q, i + 1)] == ST_CMTD);
    end

    assign bk_span = sn_dist(csn_q, bk_sn);

    always_comb begin
        if (bk_vld && int'(bk_span) < COMMIT_W) begin
            cmt_limit = CW'(bk_span);
        end else begin
            cmt_limit = CW'(COMMIT_W);
        end
        if (int'(ret_allow) < RETIRE_W) begin
            ret_limit = ret_allow;
        end else begin
            ret_limit = RW'(RETIRE_W);
        end
    end

    wt_inorder_scan #(.W(COMMIT_W)) i_cmt_scan (
        .match (cmt_match),
        .limit (cmt_limit),
        .count (cmt_cnt)
    );

    wt_inorder_scan #(.W(RETIRE_W)) i_ret_scan (
        .match (ret_match),
        .limit (ret_limit),
        .count (ret_cnt)
    );

    wt_status_ring #(
        .ISSUE_W  (ISSUE_W),
        .COMMIT_W (COMMIT_W),
        .RETIRE_W (RETIRE_W),
        .CPL_N    (CPL_N)
    ) i_ring (
        .clk     (clk),
        .rst     (rst),
        .isn     (isn_q),
        .csn     (csn_q),
        .rrp     (rrp_q),
        .grant   (iss_grant),
        .cmt_cnt (cmt_cnt),
        .ret_cnt (ret_cnt),
        .bk_vld  (bk_vld),
        .bk_sn   (bk_sn),
        .cpl_vld (cpl_vld),
        .cpl_sn  (cpl_sn_a),
        .cpl_err (cpl_err),
        .state_q (state_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            isn_q <= '0;
            csn_q <= '0;
            rrp_q <= '0;
        end else begin
            csn_q <= sn_step(csn_q, int'(cmt_cnt));
            rrp_q <= sn_step(rrp_q, int'(ret_cnt));
            isn_q <= bk_vld ? bk_sn : sn_step(isn_q, int'(iss_grant));
        end
    end

    assign iss_first_sn = sn_step(isn_q, 1);
    assign isn_o        = isn_q;
    assign csn_o        = csn_q;
    assign rrp_o        = rrp_q;
endmodule

// File: rtl/inflight_window_chk.sv
module inflight_window_chk
    import wt_pkg::*;
#(
    parameter int COMMIT_W = 8,
    parameter int IW = 3,
    parameter int CW = 4,
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [IW-1:0] iss_grant,
    input logic          full,
    input logic          bk_vld,
    input sn_t           bk_sn,
    input logic [RW-1:0] ret_allow,
    input sn_t           isn_o,
    input sn_t           csn_o,
    input sn_t           rrp_o,
    input logic [CW-1:0] cmt_cnt,
    input logic [RW-1:0] ret_cnt
);
    assert_reset_equal_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (isn_o == csn_o && csn_o == rrp_o));

    assert_issue_advance_R2: assert property (@(posedge clk) disable iff (rst)
        !bk_vld |=> isn_o == sn_t'($past(isn_o) + sn_t'($past(iss_grant))));

    assert_no_grant_when_full_R3: assert property (@(posedge clk) disable iff (rst)
        full |-> iss_grant == '0);

    assert_commit_advance_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> csn_o == sn_t'($past(csn_o) + sn_t'($past(cmt_cnt))));

    assert_commit_bound_R5: assert property (@(posedge clk) disable iff (rst)
        int'(cmt_cnt) <= COMMIT_W
        && int'(sn_dist(rrp_o, csn_o)) <= int'(sn_dist(rrp_o, isn_o)));

    assert_retire_permit_R6: assert property (@(posedge clk) disable iff (rst)
        ret_cnt <= ret_allow);

    assert_backup_target_R7: assert property (@(posedge clk) disable iff (rst)
        bk_vld |=> isn_o == $past(bk_sn));

    assert_backup_no_issue_R7: assert property (@(posedge clk) disable iff (rst)
        bk_vld |-> iss_grant == '0);
endmodule

bind inflight_window inflight_window_chk #(
    .COMMIT_W (COMMIT_W),
    .IW       (IW),
    .CW       (CW),
    .RW       (RW)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_grant (iss_grant),
    .full      (full),
    .bk_vld    (bk_vld),
    .bk_sn     (bk_sn),
    .ret_allow (ret_allow),
    .isn_o     (isn_o),
    .csn_o     (csn_o),
    .rrp_o     (rrp_o),
    .cmt_cnt   (cmt_cnt),
    .ret_cnt   (ret_cnt)
);

// File: tb/test_inflight_window.sv
module test_inflight_window;
    localparam int CLK_PERIOD = 10;
    localparam int M_FREE = 0, M_PEND = 1, M_DONE = 2, M_FAIL = 3, M_CMTD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  iss_req = '0;
    logic [2:0]  iss_grant;
    logic [5:0]  iss_first_sn;
    logic [1:0]  cpl_vld = '0;
    logic [11:0] cpl_sn = '0;
    logic [1:0]  cpl_err = '0;
    logic        bk_vld = 1'b0;
    logic [5:0]  bk_sn = '0;
    logic [2:0]  ret_allow = '0;
    logic [5:0]  isn_o, csn_o, rrp_o;
    logic        full;
    logic [3:0]  cmt_cnt;
    logic [2:0]  ret_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int mst [64];
    int misn = 0, mcsn = 0, mrrp = 0;
    logic [31:0] lfsr = 32'h1d2c_3b4a;

    always #(CLK_PERIOD / 2) clk = ~clk;

    inflight_window i_inflight_window (
        .clk (clk), .rst (rst), .iss_req (iss_req), .iss_grant (iss_grant),
        .iss_first_sn (iss_first_sn), .cpl_vld (cpl_vld), .cpl_sn (cpl_sn),
        .cpl_err (cpl_err), .bk_vld (bk_vld), .bk_sn (bk_sn), .ret_allow (ret_allow),
        .isn_o (isn_o), .csn_o (csn_o), .rrp_o (rrp_o), .full (full),
        .cmt_cnt (cmt_cnt), .ret_cnt (ret_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input int exp);
        n_chk++;
        if (act !== 32'(exp)) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rdist(input int a, input int b);
        return (b - a) & 63;
    endfunction

    // One clock cycle: drive, predict from the requirements, compare, update.
    task automatic step(input int req, input bit v0, input int s0, input bit e0,
                        input bit v1, input int s1, input bit e1,
                        input int allow, input bit bk, input int bks);
        int freen, eg, ec, er, lim;
        @(negedge clk);
        iss_req   = 3'(req);
        cpl_vld   = {v1, v0};
        cpl_sn    = {6'(s1), 6'(s0)};
        cpl_err   = {e1, e0};
        ret_allow = 3'(allow);
        bk_vld    = bk;
        bk_sn     = 6'(bks);
        #1;
        freen = 63 - rdist(mrrp, misn);
        eg = bk ? 0 : ((req < freen) ? req : freen);
        lim = bk ? rdist(mcsn, bks) : 8;
        if (lim > 8) lim = 8;
        ec = 0;
        while (ec < lim && mst[(mcsn + 1 + ec) & 63] == M_DONE) ec++;
        lim = (allow < 4) ? allow : 4;
        er = 0;
        while (er < lim && mst[(mrrp + 1 + er) & 63] == M_CMTD) er++;
        chk("R2 grant", iss_grant, eg);
        chk("R2 first serial", iss_first_sn, (misn + 1) & 63);
        chk("R3 full flag", full, (freen == 0) ? 1 : 0);
        chk("R5 commit count", cmt_cnt, ec);
        chk("R6 retire count", ret_cnt, er);
        @(posedge clk);
        if (v0 && mst[s0 & 63] == M_PEND) mst[s0 & 63] = e0 ? M_FAIL : M_DONE;
        if (v1 && mst[s1 & 63] == M_PEND) mst[s1 & 63] = e1 ? M_FAIL : M_DONE;
        for (int k = 0; k < ec; k++) mst[(mcsn + 1 + k) & 63] = M_CMTD;
        mcsn = (mcsn + ec) & 63;
        for (int k = 0; k < er; k++) mst[(mrrp + 1 + k) & 63] = M_FREE;
        mrrp = (mrrp + er) & 63;
        if (bk) begin
            for (int k = 1; k <= rdist(bks, misn); k++) mst[(bks + k) & 63] = M_FREE;
            misn = bks & 63;
        end
        for (int k = 0; k < eg; k++) mst[(misn + 1 + k) & 63] = M_PEND;
        misn = (misn + eg) & 63;
        #1;
        chk(bk ? "R7 issue pointer" : "R2 issue pointer", isn_o, misn);
        chk("R5 commit pointer", csn_o, mcsn);
        chk("R6 retire pointer", rrp_o, mrrp);
    endtask

    task automatic idle(input int allow);
        step(0, 0, 0, 0, 0, 0, 0, allow, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mst[i] = M_FREE;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1 issue pointer after reset", isn_o, 0);
        chk("R1 commit pointer after reset", csn_o, 0);
        chk("R1 retire pointer after reset", rrp_o, 0);
        chk("R1 full after reset", full, 0);
        chk("R1 commit count after reset", cmt_cnt, 0);
        chk("R1 retire count after reset", ret_cnt, 0);

        // R8: late error report on a finished entry is ignored
        step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 2, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 2, 1, 0, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        idle(0);
        chk("R8 late error ignored", csn_o, 2);

        // R4: failed entry blocks commit of younger finished ones
        step(3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 3, 0, 1, 4, 1, 0, 0, 0);
        step(0, 1, 5, 0, 0, 0, 0, 0, 0, 0);
        idle(0);
        idle(0);
        chk("R4 commit halted at failed entry", csn_o, 3);

        // R7: backup discards the failed entry and the one behind it
        step(4, 0, 0, 0, 0, 0, 0, 0, 1, 3);
        chk("R7 issue pointer rewound", isn_o, 3);
        step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 4, 0, 1, 5, 0, 0, 0, 0);
        idle(0);
        chk("R7 reissued entries commit", csn_o, 5);

        // R6: retire throttled by permission
        idle(0);
        chk("R6 zero permission holds retire", rrp_o, 0);
        idle(2);
        chk("R6 partial permission", rrp_o, 2);
        idle(4);
        chk("R6 remaining retire", rrp_o, 5);

        // R3: fill the ring
        for (int i = 0; i < 17; i++) step(4, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 window full", full, 1);
        chk("R9 issue pointer wrapped", isn_o, 4);

        // R9: drain across the wrap
        for (int i = 0; i < 32; i++) step(0, 1, (6 + 2 * i) & 63, 0, 1, (7 + 2 * i) & 63, 0, 4, 0, 0);
        for (int i = 0; i < 12; i++) idle(4);
        chk("R9 commit pointer wrapped", csn_o, 4);
        chk("R9 retire pointer wrapped", rrp_o, 4);

        // Sweep with pseudo-random traffic checked against the model
        for (int cyc = 0; cyc < 3000; cyc++) begin
            int act, req, allow, s0, s1, bks;
            bit v0, v1, e0, e1, bk;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            act   = rdist(mrrp, misn);
            req   = int'(lfsr[2:0]) % 5;
            allow = int'(lfsr[5:3]);
            v0 = 0; v1 = 0; s0 = 0; s1 = 0;
            if (act > 0) begin
                v0 = lfsr[6];
                s0 = (mrrp + 1 + int'(lfsr[13:8]) % act) & 63;
                s1 = (mrrp + 1 + int'(lfsr[19:14]) % act) & 63;
                v1 = lfsr[7] && (s1 != s0);
            end
            e0 = (lfsr[23:20] == 4'd0);
            e1 = (lfsr[27:24] == 4'd0);
            bk = 0;
            bks = 0;
            if (mst[(mcsn + 1) & 63] == M_FAIL) begin
                bk = 1;
                bks = mcsn;
            end else if (lfsr[31:27] == 5'd3) begin
                bk = 1;
                bks = (mcsn + int'(lfsr[17:12]) % (rdist(mcsn, misn) + 1)) & 63;
            end
            step(req, v0, s0, e0, v1, s1, e1, allow, bk, bks);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule